// File: doc/BRIEF.md
# Configurable I2S Slot Transmitter

This block turns a stream of audio frames, read from a show-ahead sample FIFO, into the serial data and word-select lines of an I2S-style link. A one-cycle enable marks each bit-clock period. One FIFO word covers one frame of two slots of `SLOT_W` bits each. Framing is set by static configuration inputs: the sample width, whether the first data bit trails the word-select edge by one bit clock, a one-bit sync pulse in place of a half-frame level, which slot leads the frame, whether samples sit at the start or the end of their slot, and a channel code that picks which slots carry data in stereo or mono operation.

The block also reports the FIFO packing code that matches the configured width and mono setting, so that the neighbouring packer can lay out its words. It tells the bit-clock generator whether the bus should be clocked. When the FIFO is empty at a frame boundary, the block either parks the bus or sends a silent frame, as the configuration selects. A start input gates the whole transmitter. A synchronous clear pulse returns it to the start of a frame.

Top module: `i2s_slot_tx`

## Requirements
- R1: A frame lasts 2*SLOT_W bit-clock ticks. On the first tick of a frame with the FIFO not empty, `fifo_rd` is high for that one cycle. In stereo, bits [2*SLOT_W-1:SLOT_W] of the word are the left sample and bits [SLOT_W-1:0] are the right sample. In mono, only bits [SLOT_W-1:0] are used.
- R2: Each sample is sent MSB first and occupies the low `cfg_width` bits of its slot field. With `cfg_right_align`=0 the sample starts at the first bit of the slot and the rest of the slot is zero. A `cfg_width` of 0, or one above SLOT_W, means SLOT_W.
- R3: With `cfg_right_align`=1 the sample ends at the last bit of the slot and the leading bits of the slot are zero.
- R4: With `cfg_msb_delay`=1 the serial data is the undelayed bit stream shifted one tick later, so the MSB follows the word-select edge by one bit clock. The first bit after start or clear is 0.
- R5: With `cfg_short_ws`=0, `ws` is 0 throughout the left slot and 1 throughout the right slot, and changes on the first tick of each slot.
- R6: With `cfg_short_ws`=1, `ws` is 1 only for the first tick of each frame and 0 otherwise.
- R7: With `cfg_right_lead`=1 the right slot is sent first in each frame. With 0 the left slot is sent first.
- R8: Stereo channel codes (`cfg_mono`=0): 0 sends both slots, 1 sends only the right slot, 2 sends only the left slot, and 3 to 7 send both. A slot without data is all zeros.
- R9: Mono channel codes (`cfg_mono`=1): 3 sends the sample in the right slot only, 4 in the left slot only, and every other code (1 and 2 alike) repeats it in both slots.
- R10: `pack_mode` is 0 for narrow stereo, 1 for narrow mono, 2 for wide stereo and 3 for wide mono. Narrow means an effective width of at most PACK_SPLIT bits.
- R11: If the FIFO is empty at a frame start and `cfg_stop_empty`=1, the bus halts: `tx_active`=0, no ticks are taken, and `sd` and `ws` are 0 until data arrives. With `cfg_stop_empty`=0, a frame of zero data is sent with normal `ws` and no read.
- R12: After reset, while `start` is low, and in the cycle after a `soft_clr` pulse, `sd`=`ws`=0, `tx_active` follows `start`, and no read occurs. The next tick begins a frame. `soft_clr` overrides a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear to frame start |
| start | input | 1 | Transmitter run enable |
| bclk_en | input | 1 | One-cycle pulse per bit-clock period |
| cfg_msb_delay | input | 1 | Delay data one bit clock after the word-select edge |
| cfg_short_ws | input | 1 | One-tick sync pulse instead of a slot-long level |
| cfg_right_lead | input | 1 | Right slot first in each frame |
| cfg_right_align | input | 1 | Align samples to the slot end |
| cfg_mono | input | 1 | Mono operation |
| cfg_chan | input | 3 | Channel code |
| cfg_width | input | WID_W | Sample width in bits (0 means SLOT_W) |
| cfg_stop_empty | input | 1 | Halt the bus when the FIFO is empty |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_data | input | 2*SLOT_W | Head word of the show-ahead FIFO |
| fifo_rd | output | 1 | Pop the FIFO head |
| pack_mode | output | 2 | Packing code for the FIFO writer |
| tx_active | output | 1 | Bus should be clocked |
| sd | output | 1 | Serial data |
| ws | output | 1 | Word select |

## Verification
A clear pulse can arrive in the same cycle as the bit-clock tick that would start a frame and pop a waiting FIFO word. The bench raises both together with one word queued. It then judges the result by the FIFO head not moving, by both lines being quiet, and by the following tick popping that same word and sending its MSB under the sync pulse. A second overlap occurs when the FIFO runs empty exactly at a frame boundary while stop-on-empty is set. Here the bench checks that the activity flag drops in the cycle the last frame ends.

// File: rtl/i2s_stx_pkg.sv
package i2s_stx_pkg;

   // channel codes decoded by the slot gating logic
   localparam logic [2:0] CH_BOTH   = 3'd0;
   localparam logic [2:0] CH_RIGHT  = 3'd1;
   localparam logic [2:0] CH_LEFT   = 3'd2;
   localparam logic [2:0] CH_MONO_R = 3'd3;
   localparam logic [2:0] CH_MONO_L = 3'd4;

   typedef struct packed {
      logic       msb_delay;
      logic       short_ws;
      logic       right_lead;
      logic       right_align;
      logic       mono;
      logic [2:0] chan;
   } stx_frame_cfg_t;

endpackage

// File: rtl/stx_pos_ctr.sv
module stx_pos_ctr #(
   parameter int POS_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             adv_i,
   output logic [POS_W-1:0] pos_o,
   output logic             at_start_o
);
   localparam logic [POS_W-1:0] LAST_POS = {POS_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pos_o <= '0;
      else if (clear_i)
         pos_o <= '0;
      else if (adv_i)
         pos_o <= (pos_o == LAST_POS) ? '0 : pos_o + 1'b1;
   end

   assign at_start_o = (pos_o == '0);
endmodule

// File: rtl/stx_pack_code.sv
module stx_pack_code #(
   parameter int SLOT_W     = 32,
   parameter int PACK_SPLIT = 16,
   parameter int WID_W      = 6
) (
   input  logic [WID_W-1:0] width_i,
   input  logic             mono_i,
   output logic [WID_W-1:0] eff_w_o,
   output logic [1:0]       pack_o
);
   localparam logic [WID_W-1:0] FULL_W = WID_W'(SLOT_W);
   logic wide;

   assign eff_w_o = (width_i == '0 || width_i > FULL_W) ? FULL_W : width_i;

   generate
      if (PACK_SPLIT >= SLOT_W) begin : g_all_narrow
         assign wide = 1'b0;
      end else begin : g_split
         localparam logic [WID_W-1:0] SPLIT_V = WID_W'(PACK_SPLIT);
         assign wide = (eff_w_o > SPLIT_V);
      end
   endgenerate

   assign pack_o = {wide, mono_i};
endmodule

// File: rtl/stx_bit_pick.sv
module stx_bit_pick
   import i2s_stx_pkg::*;
#(
   parameter int SLOT_W = 32,
   parameter int WID_W  = 6,
   localparam int IDX_W = $clog2(SLOT_W),
   localparam int POS_W = IDX_W + 1
) (
   input  logic [2*SLOT_W-1:0] word_i,
   input  logic [POS_W-1:0]    pos_i,
   input  stx_frame_cfg_t      cfg_i,
   input  logic [WID_W-1:0]    eff_w_i,
   output logic                bit_o,
   output logic                right_o
);
   localparam logic [WID_W:0] FULL_X = (WID_W+1)'(SLOT_W);
   localparam logic [WID_W:0] LAST_X = (WID_W+1)'(SLOT_W - 1);

   logic [SLOT_W-1:0] sample;
   logic [SLOT_W-1:0] shifted;
   logic [WID_W:0]    kx, ew, idx;
   logic              gate, in_field;

   always_comb begin
      right_o = pos_i[POS_W-1] ^ cfg_i.right_lead;
      kx      = (WID_W+1)'(pos_i[IDX_W-1:0]);
      ew      = (WID_W+1)'(eff_w_i);
      sample  = (cfg_i.mono | right_o) ? word_i[SLOT_W-1:0]
                                       : word_i[2*SLOT_W-1:SLOT_W];
      if (cfg_i.mono) begin
         case (cfg_i.chan)
            CH_MONO_R: gate = right_o;
            CH_MONO_L: gate = ~right_o;
            default:   gate = 1'b1;
         endcase
      end else begin
         case (cfg_i.chan)
            CH_RIGHT: gate = right_o;
            CH_LEFT:  gate = ~right_o;
            default:  gate = 1'b1;
         endcase
      end
      if (cfg_i.right_align) begin
         in_field = (kx >= FULL_X - ew);
         idx      = LAST_X - kx;
      end else begin
         in_field = (kx < ew);
         idx      = ew - 1'b1 - kx;
      end
      shifted = sample >> idx;
      bit_o   = gate & in_field & shifted[0];
   end
endmodule

// File: rtl/i2s_slot_tx.sv
module i2s_slot_tx
   import i2s_stx_pkg::*;
#(
   parameter int SLOT_W     = 32,
   parameter int PACK_SPLIT = 16,
   localparam int WID_W     = $clog2(SLOT_W + 1),
   localparam int WORD_W    = 2 * SLOT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_clr,
   input  logic              start,
   input  logic              bclk_en,
   input  logic              cfg_msb_delay,
   input  logic              cfg_short_ws,
   input  logic              cfg_right_lead,
   input  logic              cfg_right_align,
   input  logic              cfg_mono,
   input  logic [2:0]        cfg_chan,
   input  logic [WID_W-1:0]  cfg_width,
   input  logic              cfg_stop_empty,
   input  logic              fifo_empty,
   input  logic [WORD_W-1:0] fifo_data,
   output logic              fifo_rd,
   output logic [1:0]        pack_mode,
   output logic              tx_active,
   output logic              sd,
   output logic              ws
);
   localparam int POS_W = $clog2(SLOT_W) + 1;

   generate
      if (SLOT_W < 2 || (SLOT_W & (SLOT_W - 1)) != 0) begin : g_bad_slot
         $error("SLOT_W must be a power of two of at least 2");
      end
      if (PACK_SPLIT < 1) begin : g_bad_split
         $error("PACK_SPLIT must be positive");
      end
   endgenerate

   stx_frame_cfg_t    cfg;
   logic [POS_W-1:0]  pos;
   logic              at_start, halted, running, tick_go;
   logic [WORD_W-1:0] frame_word, cur_q;
   logic [WID_W-1:0]  eff_w;
   logic              bit_now, right_now, prev_q, sd_q, ws_q;

   assign cfg = '{msb_delay: cfg_msb_delay, short_ws: cfg_short_ws,
                  right_lead: cfg_right_lead, right_align: cfg_right_align,
                  mono: cfg_mono, chan: cfg_chan};

   assign halted     = start & at_start & fifo_empty & cfg_stop_empty;
   assign running    = start & ~halted;
   assign tick_go    = bclk_en & running & ~soft_clr;
   assign fifo_rd    = tick_go & at_start & ~fifo_empty;
   assign frame_word = at_start ? (fifo_empty ? '0 : fifo_data) : cur_q;

   stx_pos_ctr #(.POS_W(POS_W)) pos_i (
      .clk(clk), .rst_n(rst_n), .clear_i(soft_clr | ~start),
      .adv_i(tick_go), .pos_o(pos), .at_start_o(at_start)
   );

   stx_pack_code #(.SLOT_W(SLOT_W), .PACK_SPLIT(PACK_SPLIT), .WID_W(WID_W)) pack_i (
      .width_i(cfg_width), .mono_i(cfg_mono), .eff_w_o(eff_w), .pack_o(pack_mode)
   );

   stx_bit_pick #(.SLOT_W(SLOT_W), .WID_W(WID_W)) pick_i (
      .word_i(frame_word), .pos_i(pos), .cfg_i(cfg), .eff_w_i(eff_w),
      .bit_o(bit_now), .right_o(right_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         prev_q <= 1'b0;
         sd_q   <= 1'b0;
         ws_q   <= 1'b0;
      end else if (soft_clr | ~running) begin
         prev_q <= 1'b0;
         sd_q   <= 1'b0;
         ws_q   <= 1'b0;
      end else if (bclk_en) begin
         if (at_start) cur_q <= frame_word;
         prev_q <= bit_now;
         sd_q   <= cfg.msb_delay ? prev_q : bit_now;
         ws_q   <= cfg.short_ws ? at_start : right_now;
      end
   end

   assign tx_active = running;
   assign sd        = sd_q;
   assign ws        = ws_q;
endmodule

// File: rtl/i2s_slot_tx_chk.sv
module i2s_slot_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic soft_clr,
   input logic start,
   input logic bclk_en,
   input logic cfg_short_ws,
   input logic cfg_right_lead,
   input logic fifo_empty,
   input logic fifo_rd,
   input logic tx_active,
   input logic sd,
   input logic ws
);
   // R1
   rd_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |-> (!fifo_empty && bclk_en && tx_active));

   // R6
   short_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_short_ws && ws && bclk_en && start && !soft_clr) |=> !ws);

   // R7
   frame_ws_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |=> (ws == $past(cfg_short_ws | cfg_right_lead)));

   // R12
   clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_clr || !start) |=> (!sd && !ws));

   // R12
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |-> (!tx_active && !fifo_rd));
endmodule

bind i2s_slot_tx i2s_slot_tx_chk chk_i (
   .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .start(start),
   .bclk_en(bclk_en), .cfg_short_ws(cfg_short_ws), .cfg_right_lead(cfg_right_lead),
   .fifo_empty(fifo_empty), .fifo_rd(fifo_rd), .tx_active(tx_active),
   .sd(sd), .ws(ws)
);

// File: tb/i2s_slot_tx_tb.sv
module i2s_slot_tx_tb_top;
   localparam int W = 8;

   logic clk = 1'b0, rst_n = 1'b0, soft_clr = 1'b0, start = 1'b0, bclk_en = 1'b0;
   logic c_sd = 1'b0, c_sh = 1'b0, c_rl = 1'b0, c_ra = 1'b0, c_mono = 1'b0;
   logic [2:0] c_ch = 3'd0;
   logic [3:0] c_w = 4'd0;
   logic c_stop = 1'b0;
   logic fifo_empty, fifo_rd, tx_active, sd, ws;
   logic [15:0] fifo_data;
   logic [1:0] pack_mode;

   logic [15:0] fq [0:7];
   int head = 0, tail = 0;
   logic q_flush = 1'b0;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   assign fifo_empty = (head == tail);
   assign fifo_data  = fq[head % 8];

   always @(posedge clk) begin
      if (q_flush) head <= tail;
      else if (fifo_rd) head <= head + 1;
   end

   i2s_slot_tx #(.SLOT_W(W), .PACK_SPLIT(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .start(start), .bclk_en(bclk_en),
      .cfg_msb_delay(c_sd), .cfg_short_ws(c_sh), .cfg_right_lead(c_rl),
      .cfg_right_align(c_ra), .cfg_mono(c_mono), .cfg_chan(c_ch), .cfg_width(c_w),
      .cfg_stop_empty(c_stop), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
      .fifo_rd(fifo_rd), .pack_mode(pack_mode), .tx_active(tx_active), .sd(sd), .ws(ws)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk) bclk_en = 1'b1;
      @(negedge clk) bclk_en = 1'b0;
   endtask

   task automatic push(input logic [15:0] w);
      fq[tail % 8] = w;
      tail++;
   endtask

   task automatic flush();
      @(negedge clk) q_flush = 1'b1;
      @(negedge clk) q_flush = 1'b0;
   endtask

   // expected {ws, data bit} at frame position p, no msb delay
   function automatic logic [1:0] ref_pair(input logic [15:0] w, input int p);
      int k, n, idx;
      logic rt, en, b;
      logic [7:0] s;
      rt  = (p >= W) ^ c_rl;
      k   = p % W;
      n   = (c_w == 0 || int'(c_w) > W) ? W : int'(c_w);
      s   = (c_mono || rt) ? w[7:0] : w[15:8];
      if (c_mono) en = (c_ch == 3) ? rt : (c_ch == 4) ? !rt : 1'b1;
      else        en = (c_ch == 1) ? rt : (c_ch == 2) ? !rt : 1'b1;
      idx = c_ra ? (W - 1 - k) : (n - 1 - k);
      b   = en && idx >= 0 && idx < n && s[idx];
      return {c_sh ? (p == 0) : rt, b};
   endfunction

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      int widths [3] = '{3, 8, 0};
      logic [15:0] wv [2];
      int hd, errs, cfg_idx;
      logic [1:0] e;
      logic eb;

      repeat (3) @(negedge clk);
      // R12 reset state
      chk(sd == 0 && ws == 0 && tx_active == 0 && fifo_rd == 0, "R12 reset", {sd, ws, tx_active}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 packing codes (PACK_SPLIT 4, SLOT_W 8)
      c_w = 0; c_mono = 0; #1 chk(pack_mode == 2, "R10 width0 stereo", pack_mode, 2);
      c_mono = 1;          #1 chk(pack_mode == 3, "R10 width0 mono", pack_mode, 3);
      c_w = 4; c_mono = 0; #1 chk(pack_mode == 0, "R10 width4 stereo", pack_mode, 0);
      c_w = 3; c_mono = 1; #1 chk(pack_mode == 1, "R10 width3 mono", pack_mode, 1);
      c_w = 9; c_mono = 0; #1 chk(pack_mode == 2, "R10 width9 clamps", pack_mode, 2);

      // Sweep R1..R9
      cfg_idx = 0;
      for (int cf = 0; cf < 16; cf++)
         for (int ch = 0; ch < 5; ch++)
            for (int mo = 0; mo < 2; mo++)
               for (int wi = 0; wi < 3; wi++) begin
                  @(negedge clk) start = 1'b0;
                  c_sd = cf[0]; c_sh = cf[1]; c_rl = cf[2]; c_ra = cf[3];
                  c_ch = 3'(ch); c_mono = mo[0]; c_w = 4'(widths[wi]); c_stop = 1'b0;
                  flush();
                  wv[0] = 16'hA5C3 ^ 16'(cfg_idx * 16'h1357);
                  wv[1] = 16'h3C96 ^ 16'(cfg_idx * 16'h0B1D);
                  push(wv[0]); push(wv[1]);
                  start = 1'b1;
                  errs = 0;
                  for (int t = 0; t < 4 * W; t++) begin
                     tick();
                     e = ref_pair(wv[t / (2 * W)], t % (2 * W));
                     if (c_sd) begin
                        if (t == 0) eb = 1'b0;
                        else begin
                           logic [1:0] pe;
                           pe = ref_pair(wv[(t - 1) / (2 * W)], (t - 1) % (2 * W));
                           eb = pe[0];
                        end
                     end else eb = e[0];
                     if (ws !== e[1] || sd !== eb) begin
                        if (errs == 0)
                           $display("  cfg %0d tick %0d ws=%b/%b sd=%b/%b", cfg_idx, t, ws, e[1], sd, eb);
                        errs++;
                     end
                  end
                  if (errs != 0 || head != tail)
                     errs++;
                  // R1 R2 R3 R4 R5 R6 R7 R8 R9 serial stream per configuration
                  chk(errs == 0, $sformatf("R1-stream cfg%0d R2 R3 R4 R5 R6 R7 R8 R9", cfg_idx),
                      errs, 0);
                  cfg_idx++;
               end

      // R11 stop on empty
      @(negedge clk) start = 1'b0;
      c_sd = 0; c_sh = 0; c_rl = 0; c_ra = 0; c_mono = 0; c_ch = 0; c_w = 0; c_stop = 1;
      flush();
      start = 1'b1;
      #1 chk(tx_active == 0, "R11 halted when empty", tx_active, 0);
      hd = head;
      tick(); tick();
      chk(sd == 0 && ws == 0 && head == hd, "R11 halted bus quiet", {sd, ws}, 0);
      push(16'hB2E7);
      #1 chk(tx_active == 1, "R11 resumes on data", tx_active, 1);
      tick();
      chk(sd == 1'b1 && head == hd + 1, "R11 first bit after resume", sd, 1);
      for (int t = 1; t < 2 * W; t++) tick();
      #1 chk(tx_active == 0, "R11 halts at frame end", tx_active, 0);

      // R11 keep clocking without stop
      @(negedge clk) start = 1'b0;
      c_stop = 0;
      flush();
      start = 1'b1;
      #1 chk(tx_active == 1, "R11 active without stop", tx_active, 1);
      hd = head; errs = 0;
      for (int t = 0; t < 2 * W; t++) begin
         tick();
         if (sd !== 1'b0 || ws !== (t >= W)) errs++;
      end
      chk(errs == 0 && head == hd, "R11 silent frame", errs, 0);

      // R12 clear coincident with a frame-start tick
      @(negedge clk) start = 1'b0;
      c_sh = 1;
      flush();
      push(16'h81C4);
      start = 1'b1;
      hd = head;
      @(negedge clk) begin bclk_en = 1'b1; soft_clr = 1'b1; end
      @(negedge clk) begin bclk_en = 1'b0; soft_clr = 1'b0; end
      chk(head == hd && sd == 0 && ws == 0, "R12 clear beats tick", head - hd, 0);
      tick();
      chk(head == hd + 1 && ws == 1 && sd == 1, "R12 word kept after clear", {ws, sd}, 3);

      // R12 start dropped mid-frame
      repeat (4) tick();
      @(negedge clk) start = 1'b0;
      @(negedge clk);
      chk(sd == 0 && ws == 0 && tx_active == 0, "R12 stop mid-frame", {sd, ws, tx_active}, 0);
      push(16'h7F00);
      hd = head;
      start = 1'b1;
      tick();
      chk(head == hd + 1 && ws == 1 && sd == 0, "R12 restart at frame start", {ws, sd}, 2);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule